// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures one complex Fourier coefficient of a stream of 12-bit converter samples at the current point of a frequency sweep. For every accepted sample it removes the mid-scale offset and optionally applies a raised-cosine taper. It then multiplies the result by the cosine and by the negated sine of the reference phase that comes with the sample, and adds the two products into separate real and imaginary accumulators. After a fixed record of 1024 samples, both sums are scaled down into 16-bit signed words and a one-cycle done flag is raised.

A sweep controller pulses `start_i` once per frequency point, then delivers samples with `smp_vld_i`, each with the reference phase in `phase_i`. Gaps between samples are allowed. The results stay on the outputs until the next start, so the controller can read them at its leisure. The reference sine and cosine come from a quarter-wave table that is computed at elaboration and addressed by the phase bits.

Top module: `dft_bin_correlator`

## Requirements
- R1: After reset `re_o` and `im_o` are zero and `done_o` is low.
- R2: A start pulse opens a new record of exactly 1024 samples. A sample presented in the same cycle as `start_i` is not part of the record.
- R3: Only cycles with `smp_vld_i` high count toward the record, so idle cycles may be mixed in. `done_o` is high for exactly one cycle, a few cycles after the 1024th accepted sample, and never before it.
- R4: Each sample code is offset binary: the signed value is code − 2048 (code 2048 is zero, code 4095 is +2047, code 0 is −2048).
- R5: The real sum is Σ x·cos(θ) and the imaginary sum is Σ −x·sin(θ), where θ is the 12-bit `phase_i` of each sample. The reference peak is 2047. At phase 0x000, cos=2047 and sin=0. At 0x400, cos=0 and sin=2047. At 0x800, cos=−2047 and sin=0. At 0xC00, cos=0 and sin=−2047. Adding 0x800 to a phase negates both values.
- R6: Each output is its full-precision sum shifted right arithmetically by 16 bits, then clamped to the range −32768..32767.
- R7: With `win_en_i` low the sample passes unchanged. With `win_en_i` high, sample number n (0-based within the record) is scaled: x·w >>> 11, where w = (2047 − cos(4n)) >> 1 and cos uses the same 12-bit reference table. This gives w=0 at n=0, w=1023 at n=256 and w=2047 at n=512.
- R8: Once a record is complete, further valid samples are ignored until the next start: no further done pulse and no change of `re_o` or `im_o`.
- R9: A start pulse clears `re_o` and `im_o` to zero in the cycle after it, and any record in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a new record and clears results |
| win_en_i | input | 1 | Enables the raised-cosine taper |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 12 | Offset-binary sample code |
| phase_i | input | 12 | Reference phase for this sample |
| re_o | output | 16 | Signed real result |
| im_o | output | 16 | Signed imaginary result |
| done_o | output | 1 | One-cycle pulse when results are ready |

## Verification
The checker assumes that `start_i`, `smp_vld_i` and `phase_i` are known in every cycle after reset. It also assumes that a record ends either by its 1024th accepted sample or by a new start, never by a change of `win_en_i` halfway through. The bench drives every input at the falling edge with defined values from the first cycle. It sets the taper enable together with the start pulse and holds it for the whole record. The reference-axis check relies on phase 0 being a legal input at any time, and the stimulus uses it freely.

// File: rtl/corr_pkg.sv
// Shared helpers for the single-bin correlator.
// Assumes: callers pass small positive table sizes; math is done in longint.
package corr_pkg;

    // Integer rational approximation of sin over a quarter wave.
    // k runs 0..q; exact zero at k=0 and exact peak amp at k=q.
    function automatic longint sine_point(input longint k, input longint q, input longint amp);
        longint num;
        longint den;
        num = 4 * k * (2 * q - k);
        den = 5 * q * q - k * (2 * q - k);
        return (amp * num) / den;
    endfunction

endpackage

// File: rtl/corr_sine_lut.sv
// Quarter-wave sine lookup, combinational.
// QUAD_OFS=0 gives sin(phase); QUAD_OFS=1 gives cos(phase) by a quarter turn.
// Assumes: the full phase word is used, top two bits select the quadrant.
module corr_sine_lut #(
    parameter int PH_W     = 12,
    parameter int TRIG_W   = 12,
    parameter int QUAD_OFS = 0
) (
    input  logic [PH_W-1:0]          phase,
    output logic signed [TRIG_W-1:0] value
);
    localparam int LUT_BITS = PH_W - 2;
    localparam int Q        = 1 << LUT_BITS;
    localparam int AMP      = (1 << (TRIG_W - 1)) - 1;

    logic signed [TRIG_W-1:0] tbl [0:Q];
    logic [1:0]               quad;
    logic [LUT_BITS-1:0]      k;
    logic [LUT_BITS:0]        addr;
    logic signed [TRIG_W-1:0] mag;

    // Build the quarter-wave table from the approximation function.
    for (genvar i = 0; i <= Q; i++) begin : g_pt
        assign tbl[i] = TRIG_W'(corr_pkg::sine_point(longint'(i), longint'(Q), longint'(AMP)));
    end

    // Fold the phase into the first quadrant, look up, restore the sign.
    always_comb begin
        quad = phase[PH_W-1 -: 2] + 2'(QUAD_OFS);
        k    = phase[LUT_BITS-1:0];
        addr = quad[0] ? ((LUT_BITS+1)'(Q) - {1'b0, k}) : {1'b0, k};
        mag  = tbl[addr];
        value = quad[1] ? -mag : mag;
    end
endmodule

// File: rtl/corr_window.sv
// Window stage: one register stage that optionally scales the signed sample
// by a non-negative coefficient with FRAC fraction bits.
// Assumes: coef <= 2^FRAC - 1, so the scaled value fits the sample width.
module corr_window #(
    parameter int SMP_W  = 12,
    parameter int TRIG_W = 12,
    parameter int FRAC   = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     in_vld,
    input  logic                     in_last,
    input  logic                     in_win,
    input  logic signed [SMP_W-1:0]  in_x,
    input  logic [TRIG_W-1:0]        in_coef,
    input  logic signed [TRIG_W-1:0] in_cos,
    input  logic signed [TRIG_W-1:0] in_sin,
    output logic                     out_vld,
    output logic                     out_last,
    output logic signed [SMP_W-1:0]  out_x,
    output logic signed [TRIG_W-1:0] out_cos,
    output logic signed [TRIG_W-1:0] out_sin
);
    localparam int WP_W = SMP_W + TRIG_W + 1;

    logic signed [WP_W-1:0] wprod;

    // Tapered sample in full precision.
    always_comb wprod = in_x * $signed({1'b0, in_coef});

    // Register the tapered (or bypassed) sample with its reference values.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_x    <= '0;
            out_cos  <= '0;
            out_sin  <= '0;
        end else begin
            out_vld  <= in_vld;
            out_last <= in_last;
            out_x    <= in_win ? SMP_W'(wprod >>> FRAC) : in_x;
            out_cos  <= in_cos;
            out_sin  <= in_sin;
        end
    end
endmodule

// File: rtl/corr_mac.sv
// Multiply-accumulate and output stage: products in one register stage,
// sums in the next; on the record's last sample the scaled and clamped
// results are loaded and done pulses for one cycle.
// Assumes: ACC_W is wide enough for a whole record without overflow.
module corr_mac #(
    parameter int SMP_W     = 12,
    parameter int TRIG_W    = 12,
    parameter int CNT_W     = 10,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     in_vld,
    input  logic                     in_last,
    input  logic signed [SMP_W-1:0]  in_x,
    input  logic signed [TRIG_W-1:0] in_cos,
    input  logic signed [TRIG_W-1:0] in_sin,
    output logic signed [OUT_W-1:0]  re_out,
    output logic signed [OUT_W-1:0]  im_out,
    output logic                     done
);
    localparam int PROD_W = SMP_W + TRIG_W + 1;
    localparam int ACC_W  = PROD_W + CNT_W;
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

    logic signed [PROD_W-1:0] p_re, p_im;
    logic                     c_vld, c_last;
    logic signed [ACC_W-1:0]  acc_re, acc_im, nxt_re, nxt_im;

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] s);
        logic signed [ACC_W-1:0] sh;
        sh = s >>> OUT_SHIFT;
        if (sh > HI)      return OUT_W'(HI);
        else if (sh < LO) return OUT_W'(LO);
        else              return OUT_W'(sh);
    endfunction

    // Form the real and negated-imaginary products.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            p_re   <= '0;
            p_im   <= '0;
            c_vld  <= 1'b0;
            c_last <= 1'b0;
        end else begin
            p_re   <= in_x * in_cos;
            p_im   <= -(in_x * in_sin);
            c_vld  <= in_vld;
            c_last <= in_last;
        end
    end

    // Next accumulator values including the product now arriving.
    always_comb begin
        nxt_re = acc_re + p_re;
        nxt_im = acc_im + p_im;
    end

    // Accumulate and publish the result on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_re <= '0;
            acc_im <= '0;
            re_out <= '0;
            im_out <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (c_vld) begin
                acc_re <= nxt_re;
                acc_im <= nxt_im;
                if (c_last) begin
                    re_out <= clip(nxt_re);
                    im_out <= clip(nxt_im);
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dft_bin_correlator.sv
// Single-bin DFT correlator top: record control, sample conversion,
// reference and window lookups, then window and MAC stages.
// Assumes: REC_LEN is a power of two no larger than 2^PH_W; samples are
// offset binary; phase_i is the reference phase of the same sample.
module dft_bin_correlator #(
    parameter int SMP_W     = 12,
    parameter int PH_W      = 12,
    parameter int TRIG_W    = 12,
    parameter int REC_LEN   = 1024,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             win_en_i,
    input  logic             smp_vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [OUT_W-1:0] re_o,
    output logic [OUT_W-1:0] im_o,
    output logic             done_o
);
    localparam int CNT_W    = $clog2(REC_LEN);
    localparam int TRIG_AMP = (1 << (TRIG_W - 1)) - 1;
    localparam int WIN_FRAC = TRIG_W - 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(REC_LEN - 1);

    logic                     busy;
    logic [CNT_W-1:0]         cnt;
    logic                     take;
    logic [PH_W-1:0]          win_phase;
    logic signed [TRIG_W-1:0] ref_cos, ref_sin, win_cos;
    logic signed [TRIG_W+1:0] cdiff;
    logic [TRIG_W-1:0]        coef;

    logic                     a_vld, a_last, a_win;
    logic signed [SMP_W-1:0]  a_x;
    logic [TRIG_W-1:0]        a_coef;
    logic signed [TRIG_W-1:0] a_cos, a_sin;

    logic                     b_vld, b_last;
    logic signed [SMP_W-1:0]  b_x;
    logic signed [TRIG_W-1:0] b_cos, b_sin;

    logic signed [OUT_W-1:0]  re_s, im_s;

    // A sample is taken only inside a record and never on a start cycle.
    always_comb take = busy && smp_vld_i && !start_i;

    // Record control: open on start, count samples, close after the last.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start_i) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (take) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == LAST_IDX) busy <= 1'b0;
        end
    end

    // Window reference phase: sample index spread over a full turn.
    always_comb win_phase = PH_W'(cnt) << (PH_W - CNT_W);

    corr_sine_lut #(.PH_W(PH_W), .TRIG_W(TRIG_W), .QUAD_OFS(1)) u_cos (
        .phase(phase_i), .value(ref_cos));
    corr_sine_lut #(.PH_W(PH_W), .TRIG_W(TRIG_W), .QUAD_OFS(0)) u_sin (
        .phase(phase_i), .value(ref_sin));
    corr_sine_lut #(.PH_W(PH_W), .TRIG_W(TRIG_W), .QUAD_OFS(1)) u_wcos (
        .phase(win_phase), .value(win_cos));

    // Raised-cosine coefficient (peak - cos) / 2.
    always_comb begin
        cdiff = (TRIG_W+2)'(TRIG_AMP) - (TRIG_W+2)'(win_cos);
        coef  = TRIG_W'(cdiff >>> 1);
    end

    // Stage A: convert to signed and register the lookups.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            a_vld  <= 1'b0;
            a_last <= 1'b0;
            a_win  <= 1'b0;
            a_x    <= '0;
            a_coef <= '0;
            a_cos  <= '0;
            a_sin  <= '0;
        end else begin
            a_vld  <= take;
            a_last <= take && (cnt == LAST_IDX);
            a_win  <= win_en_i;
            a_x    <= {~smp_i[SMP_W-1], smp_i[SMP_W-2:0]};
            a_coef <= coef;
            a_cos  <= ref_cos;
            a_sin  <= ref_sin;
        end
    end

    corr_window #(.SMP_W(SMP_W), .TRIG_W(TRIG_W), .FRAC(WIN_FRAC)) u_win (
        .clk(clk_i), .rst_n(rst_ni), .flush(start_i),
        .in_vld(a_vld), .in_last(a_last), .in_win(a_win), .in_x(a_x),
        .in_coef(a_coef), .in_cos(a_cos), .in_sin(a_sin),
        .out_vld(b_vld), .out_last(b_last), .out_x(b_x),
        .out_cos(b_cos), .out_sin(b_sin));

    corr_mac #(.SMP_W(SMP_W), .TRIG_W(TRIG_W), .CNT_W(CNT_W),
               .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_mac (
        .clk(clk_i), .rst_n(rst_ni), .flush(start_i),
        .in_vld(b_vld), .in_last(b_last), .in_x(b_x),
        .in_cos(b_cos), .in_sin(b_sin),
        .re_out(re_s), .im_out(im_s), .done(done_o));

    // Drive the plain output ports.
    always_comb begin
        re_o = re_s;
        im_o = im_s;
    end
endmodule

// File: rtl/corr_chk.sv
// Property checker for the correlator, bound to the top module.
// Keeps its own count of accepted samples to judge the done pulse.
module corr_chk #(
    parameter int REC_LEN = 1024,
    parameter int TRIG_W  = 12,
    parameter int PH_W    = 12,
    parameter int OUT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     smp_vld_i,
    input logic [PH_W-1:0]          phase_i,
    input logic signed [TRIG_W-1:0] ref_cos,
    input logic signed [TRIG_W-1:0] ref_sin,
    input logic [OUT_W-1:0]         re_o,
    input logic [OUT_W-1:0]         im_o,
    input logic                     done_o
);
    localparam int CW  = $clog2(REC_LEN) + 1;
    localparam int AMP = (1 << (TRIG_W - 1)) - 1;

    logic          armed;
    logic [CW-1:0] seen;

    // Independent tally of samples that belong to the current record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            seen  <= '0;
        end else if (start_i) begin
            armed <= 1'b1;
            seen  <= '0;
        end else if (armed && smp_vld_i) begin
            seen <= seen + CW'(1);
            if (seen == CW'(REC_LEN - 1)) armed <= 1'b0;
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seen == CW'(REC_LEN) && !armed));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || ($stable(re_o) && $stable(im_o))));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (re_o == '0 && im_o == '0 && !done_o));

    // R5
    axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == '0) |-> (ref_cos == TRIG_W'(AMP) && ref_sin == '0));
endmodule

bind dft_bin_correlator corr_chk #(
    .REC_LEN(REC_LEN), .TRIG_W(TRIG_W), .PH_W(PH_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .start_i(start_i), .smp_vld_i(smp_vld_i),
    .phase_i(phase_i), .ref_cos(ref_cos), .ref_sin(ref_sin),
    .re_o(re_o), .im_o(im_o), .done_o(done_o));

// File: tb/tb_dft_bin_correlator.sv
module tb_dft_bin_correlator;
    localparam int CLK_PERIOD = 10;
    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, win = 1'b0, vld = 1'b0;
    logic [11:0] smp = 12'd2048, ph = 12'd0;
    logic [15:0] re, im;
    logic        done;

    int total = 0, bad = 0;
    int got_re, got_im, dones, early;

    dft_bin_correlator dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .win_en_i(win),
        .smp_vld_i(vld), .smp_i(smp), .phase_i(ph),
        .re_o(re), .im_o(im), .done_o(done));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        longint s;
        s = v >>> 16;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return int'(s);
    endfunction

    // One record: start, 1024 samples, then wait for done.
    task automatic run_rec(input bit w, input logic [11:0] base, input logic [11:0] p,
                           input int spike_at, input logic [11:0] spike,
                           input bit alt, input bit gaps, input bit start_smp);
        dones = 0; early = 0; got_re = 0; got_im = 0;
        @(negedge clk);
        start = 1'b1; win = w; vld = start_smp; smp = 12'd4095; ph = 12'd0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 3 == 0)) begin
                vld = 1'b0;
                @(negedge clk);
                if (done) early++;
            end
            vld = 1'b1;
            smp = (i == spike_at) ? spike : base;
            ph  = (alt && i[0]) ? p + 12'h800 : p;
            @(negedge clk);
            if (done) early++;
        end
        vld = 1'b0;
        for (int c = 0; c < 12; c++) begin
            if (done) begin
                if (dones == 0) begin
                    got_re = int'($signed(re));
                    got_im = int'($signed(im));
                end
                dones++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 re after reset", int'($signed(re)), 0);
        chk("R1 im after reset", int'($signed(im)), 0);
        chk("R1 done after reset", int'(done), 0);
    endtask

    // Constant sample at a cardinal phase with known reference values.
    task automatic t_const(input string tag, input logic [11:0] code,
                           input logic [11:0] p, input int c, input int s);
        longint x;
        x = longint'(code) - 2048;
        run_rec(1'b0, code, p, -1, 12'd0, 1'b0, 1'b0, 1'b0);
        chk({tag, " re"}, got_re, sat16(longint'(N) * x * c));
        chk({tag, " im"}, got_im, sat16(-longint'(N) * x * s));
        chk({tag, " single done"}, dones, 1);
    endtask

    task automatic t_antisym();
        run_rec(1'b0, 12'd3000, 12'h123, -1, 12'd0, 1'b1, 1'b0, 1'b0);
        chk("R5 half-turn cancel re", got_re, 0);
        chk("R5 half-turn cancel im", got_im, 0);
    endtask

    task automatic t_gaps();
        run_rec(1'b0, 12'd2148, 12'h000, -1, 12'd0, 1'b0, 1'b1, 1'b0);
        chk("R3 gaps re", got_re, sat16(longint'(N) * 100 * 2047));
        chk("R3 no early done", early, 0);
        chk("R3 one done pulse", dones, 1);
    endtask

    task automatic t_start_sample();
        run_rec(1'b0, 12'd2148, 12'h000, -1, 12'd0, 1'b0, 1'b0, 1'b1);
        chk("R2 start-cycle sample ignored", got_re, sat16(longint'(N) * 100 * 2047));
    endtask

    task automatic t_after_done();
        int hold_re, hold_im, late;
        hold_re = int'($signed(re));
        hold_im = int'($signed(im));
        late = 0;
        for (int i = 0; i < 20; i++) begin
            vld = 1'b1; smp = 12'd4095; ph = 12'h400;
            @(negedge clk);
            if (done) late++;
        end
        vld = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) late++;
        end
        chk("R8 no done after record", late, 0);
        chk("R8 re held", int'($signed(re)), hold_re);
        chk("R8 im held", int'($signed(im)), hold_im);
    endtask

    task automatic t_clear();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 re cleared", int'($signed(re)), 0);
        chk("R9 im cleared", int'($signed(im)), 0);
    endtask

    // Single spike at index n, phase 0; window cos(4n) known at n=0,256,512.
    task automatic t_window(input string tag, input bit w, input int n,
                            input logic [11:0] code, input int wc);
        longint x, coef, wx;
        x = longint'(code) - 2048;
        coef = (2047 - wc) >>> 1;
        wx = w ? ((x * coef) >>> 11) : x;
        run_rec(w, 12'd2048, 12'h000, n, code, 1'b0, 1'b0, 1'b0);
        chk(tag, got_re, sat16(wx * 2047));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_const("R5 phase 0", 12'd2148, 12'h000, 2047, 0);
        t_const("R5 phase quarter", 12'd2148, 12'h400, 0, 2047);
        t_const("R5 phase half", 12'd1948, 12'h800, -2047, 0);
        t_const("R5 phase three-quarter", 12'd1948, 12'hC00, 0, -2047);
        t_const("R4 mid-scale is zero", 12'd2048, 12'h000, 2047, 0);
        t_const("R4 below mid-scale", 12'd2000, 12'h000, 2047, 0);
        t_const("R6 clamp high", 12'd4095, 12'h000, 2047, 0);
        t_const("R6 clamp low", 12'd0, 12'h000, 2047, 0);
        t_antisym();
        t_gaps();
        t_start_sample();
        t_after_done();
        t_clear();
        t_window("R7 window zero at n=0", 1'b1, 0, 12'd4095, 2047);
        t_window("R7 bypass at n=0", 1'b0, 0, 12'd4095, 2047);
        t_window("R7 window n=256 positive", 1'b1, 256, 12'd4095, 0);
        t_window("R7 window n=256 negative", 1'b1, 256, 12'd0, 0);
        t_window("R7 window n=512", 1'b1, 512, 12'd4095, -2047);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule